// File: doc/BRIEF.md
# LIN Transceiver Operating-Mode Controller

This block is the synchronous mode logic of a single-wire LIN bus transceiver. It watches the enable pin, a logic-supply undervoltage flag, an overtemperature flag, the transmit data bit and a digitised "bus is dominant" flag from an external comparator. From these it decides which of three operating modes the transceiver is in: standby, normal or sleep. It drives the regulator-inhibit control, the slave termination switch, the transmitter enable with the gated transmit level, the receive data line and a mode status code. Analog behaviour such as slew shaping, current limiting and threshold comparison lives outside.

All time windows are counted in ticks of a one-microsecond strobe, `tick_us`. Two windows exist. The enable-low debounce guards the normal-to-sleep transition. The bus-dominant wake filter guards remote wake-up from sleep. A remote wake-up does not return the node to normal mode. It lands in standby, powers the regulator again and pulls the receive line low as an interrupt, which stays until the host raises the enable pin. Thermal shutdown only silences the transmitter; the mode itself is kept, so recovery is automatic.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, the block is in standby: `mode_code`=00, `inh_drive`=1, `term_en`=1, `tx_enable`=0, `tx_dom`=0, `rxd`=1, `tsd_flag`=0.
- R2: In standby, `en_pin`=1 with `vcc_uv`=0 moves the block to normal (`mode_code`=01) at the next clock edge; while `vcc_uv`=1 it stays in standby.
- R3: Normal mode moves to sleep only after `en_pin` has been low for `DEB_TICKS` consecutive ticks, and only if it is still low one clock later; a low shorter than that leaves the mode at normal and restarts the count. Sleep is entered from no other mode.
- R4: In sleep (`mode_code`=10) both `inh_drive` and `term_en` are 0; in every other mode both are 1.
- R5: In sleep, `bus_dom`=1 held for `WAKE_TICKS` consecutive ticks (and still high one clock later) moves the block to standby; a shorter dominant pulse leaves it in sleep.
- R6: After such a remote wake-up, `rxd` is 0 in standby, whatever the bus does, until the block enters normal mode.
- R7: In sleep, `en_pin`=1 with `vcc_uv`=0 moves the block straight to normal at the next clock edge (local wake-up), taking priority over a remote wake-up.
- R8: In normal mode, `vcc_uv`=1 moves the block to standby at the next clock edge, ahead of any sleep request, and `tx_enable` is 0 while `vcc_uv`=1.
- R9: `over_temp`=1 sets `tsd_flag`=1 and forces `tx_enable`=0 without changing `mode_code`; the receive path keeps working and the transmitter returns once the flag clears.
- R10: `tx_enable` is 1 only in normal mode with `over_temp`=0 and `vcc_uv`=0; `tx_dom` equals `tx_enable` AND NOT `txd` (txd=1 is recessive).
- R11: The mode code is 00 standby, 01 normal, 10 sleep; in normal mode without a pending wake interrupt `rxd` is the inverse of `bus_dom` one clock later, and in standby without an interrupt and in sleep `rxd` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| en_pin | input | 1 | Host enable level |
| vcc_uv | input | 1 | Logic supply missing or under threshold |
| over_temp | input | 1 | Junction overtemperature flag |
| txd | input | 1 | Transmit bit, 0 = dominant |
| bus_dom | input | 1 | Digitised bus level, 1 = dominant |
| inh_drive | output | 1 | 1 = drive inhibit high, 0 = float |
| term_en | output | 1 | Slave termination connected |
| tx_enable | output | 1 | Transmitter permitted |
| tx_dom | output | 1 | Drive bus dominant |
| rxd | output | 1 | Receive data, 0 = dominant or wake interrupt |
| mode_code | output | 2 | 00 standby, 01 normal, 10 sleep |
| tsd_flag | output | 1 | Thermal shutdown active |

## Verification
Every level-driven result (gating of the transmitter, the receive path, the thermal flag, the undervoltage and enable transitions) is due at the first rising edge after the input changes, so the bench moves inputs on the falling edge and compares on the following falling edge. Timed transitions are due one edge after the tick that fills the window, and the directed steps hold the input a dozen cycles past the window before looking, or release it well short of it to prove nothing moved. A cycle model in the bench, written from the requirements, predicts every output for every falling edge under random input segments.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

    typedef enum logic [1:0] {
        MODE_STBY  = 2'b00,
        MODE_NORM  = 2'b01,
        MODE_SLEEP = 2'b10
    } lin_mode_e;

    typedef struct packed {
        lin_mode_e mode;
        logic      wake_irq;
    } fsm_state_t;

    typedef struct packed {
        logic inh;
        logic term;
        logic tx_en;
        logic tx_dom;
        logic rxd;
        logic tsd;
    } pin_out_t;

endpackage

// File: rtl/lin_tick_filter.sv
module lin_tick_filter #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    input  logic level,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm || !level) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != LIM_C)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIM_C);

    // R3 and R5: an interrupted window restarts from zero
    a_r3_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(arm && level) |=> (cnt_q == '0));

    // R5: each tick inside an open window advances the count by one
    a_r5_window_step: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && level && tick && (cnt_q != LIM_C)) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
    import lin_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_pin,
    input  logic       vcc_uv,
    input  logic       bus_dom,
    input  logic       deb_done,
    input  logic       wake_done,
    output fsm_state_t state_d,
    output lin_mode_e  mode_q
);
    fsm_state_t state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q.mode)
            MODE_STBY: begin
                if (en_pin && !vcc_uv) begin
                    state_d.mode     = MODE_NORM;
                    state_d.wake_irq = 1'b0;
                end
            end
            MODE_NORM: begin
                state_d.wake_irq = 1'b0;
                if (vcc_uv) begin
                    state_d.mode = MODE_STBY;
                end else if (deb_done && !en_pin) begin
                    state_d.mode = MODE_SLEEP;
                end
            end
            MODE_SLEEP: begin
                if (en_pin && !vcc_uv) begin
                    state_d.mode     = MODE_NORM;
                    state_d.wake_irq = 1'b0;
                end else if (wake_done && bus_dom) begin
                    state_d.mode     = MODE_STBY;
                    state_d.wake_irq = 1'b1;
                end
            end
            default: begin
                state_d.mode     = MODE_STBY;
                state_d.wake_irq = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.mode     <= MODE_STBY;
            state_q.wake_irq <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mode_q = state_q.mode;

    // R3: sleep is only ever entered from normal mode
    a_r3_sleep_source: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.mode == MODE_SLEEP && $past(state_q.mode) != MODE_SLEEP)
        |-> ($past(state_q.mode) == MODE_NORM));

    // R7: leaving sleep towards normal requires the enable pin
    a_r7_local_wake: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q.mode) == MODE_SLEEP && state_q.mode == MODE_NORM) |-> $past(en_pin));

    // R8: undervoltage in normal mode always lands in standby
    a_r8_uv_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q.mode) == MODE_NORM && $past(vcc_uv)) |-> (state_q.mode == MODE_STBY));

    // R6: a pending wake interrupt only exists in standby
    a_r6_irq_in_stby: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.wake_irq |-> (state_q.mode == MODE_STBY));

    // R11: the mode register never holds the unused code
    a_r11_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.mode != 2'b11);

endmodule

// File: rtl/lin_pin_stage.sv
module lin_pin_stage
    import lin_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fsm_state_t state_d,
    input  lin_mode_e  mode_q,
    input  logic       txd,
    input  logic       bus_dom,
    input  logic       over_temp,
    input  logic       vcc_uv,
    output pin_out_t   pins_q
);
    pin_out_t pins_d;

    always_comb begin
        pins_d.inh    = (state_d.mode != MODE_SLEEP);
        pins_d.term   = (state_d.mode != MODE_SLEEP);
        pins_d.tx_en  = (state_d.mode == MODE_NORM) && !over_temp && !vcc_uv;
        pins_d.tx_dom = pins_d.tx_en && !txd;
        if (state_d.wake_irq) begin
            pins_d.rxd = 1'b0;
        end else if (state_d.mode == MODE_NORM) begin
            pins_d.rxd = !bus_dom;
        end else begin
            pins_d.rxd = 1'b1;
        end
        pins_d.tsd    = over_temp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q.inh    <= 1'b1;
            pins_q.term   <= 1'b1;
            pins_q.tx_en  <= 1'b0;
            pins_q.tx_dom <= 1'b0;
            pins_q.rxd    <= 1'b1;
            pins_q.tsd    <= 1'b0;
        end else begin
            pins_q <= pins_d;
        end
    end

    // R4: sleep floats the inhibit and drops the termination
    a_r4_sleep_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SLEEP) |-> (!pins_q.inh && !pins_q.term));

    // R10: the bus is only pulled dominant from normal mode
    a_r10_tx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        pins_q.tx_dom |-> (pins_q.tx_en && mode_q == MODE_NORM));

    // R9: thermal shutdown silences the transmitter
    a_r9_tsd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pins_q.tsd |-> !pins_q.tx_en);

    // R11: receive follows the bus one clock later in normal mode
    a_r11_rx_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_d.mode) == MODE_NORM && !$past(state_d.wake_irq))
        |-> (pins_q.rxd == !$past(bus_dom)));

endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int DEB_TICKS  = 20,
    parameter int WAKE_TICKS = 90
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       en_pin,
    input  logic       vcc_uv,
    input  logic       over_temp,
    input  logic       txd,
    input  logic       bus_dom,
    output logic       inh_drive,
    output logic       term_en,
    output logic       tx_enable,
    output logic       tx_dom,
    output logic       rxd,
    output logic [1:0] mode_code,
    output logic       tsd_flag
);
    fsm_state_t state_d;
    lin_mode_e  mode_q;
    pin_out_t   pins_q;
    logic       deb_done;
    logic       wake_done;

    lin_tick_filter #(.LIMIT(DEB_TICKS)) u_en_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_us),
        .arm     (mode_q == MODE_NORM),
        .level   (!en_pin),
        .expired (deb_done)
    );

    lin_tick_filter #(.LIMIT(WAKE_TICKS)) u_wake_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_us),
        .arm     (mode_q == MODE_SLEEP),
        .level   (bus_dom),
        .expired (wake_done)
    );

    lin_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_pin    (en_pin),
        .vcc_uv    (vcc_uv),
        .bus_dom   (bus_dom),
        .deb_done  (deb_done),
        .wake_done (wake_done),
        .state_d   (state_d),
        .mode_q    (mode_q)
    );

    lin_pin_stage u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d   (state_d),
        .mode_q    (mode_q),
        .txd       (txd),
        .bus_dom   (bus_dom),
        .over_temp (over_temp),
        .vcc_uv    (vcc_uv),
        .pins_q    (pins_q)
    );

    assign inh_drive = pins_q.inh;
    assign term_en   = pins_q.term;
    assign tx_enable = pins_q.tx_en;
    assign tx_dom    = pins_q.tx_dom;
    assign rxd       = pins_q.rxd;
    assign tsd_flag  = pins_q.tsd;
    assign mode_code = mode_q;

endmodule

// File: tb/lin_mode_ctrl_tb.sv
`timescale 1ns/1ps
module lin_mode_ctrl_tb_top;
    localparam int DEB  = 20;
    localparam int WAKE = 90;
    localparam int TDIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b0;
    logic en_pin = 1'b0, vcc_uv = 1'b0, over_temp = 1'b0, txd = 1'b1, bus_dom = 1'b0;
    logic inh_drive, term_en, tx_enable, tx_dom, rxd, tsd_flag;
    logic [1:0] mode_code;

    int n_chk = 0, n_fail = 0, cyc = 0, tdiv = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    lin_mode_ctrl #(.DEB_TICKS(DEB), .WAKE_TICKS(WAKE)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .en_pin(en_pin),
        .vcc_uv(vcc_uv), .over_temp(over_temp), .txd(txd), .bus_dom(bus_dom),
        .inh_drive(inh_drive), .term_en(term_en), .tx_enable(tx_enable),
        .tx_dom(tx_dom), .rxd(rxd), .mode_code(mode_code), .tsd_flag(tsd_flag));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // one-microsecond strobe
    always @(negedge clk) begin
        tdiv    = (tdiv + 1) % TDIV;
        tick_us <= (tdiv == 0);
    end

    // reference model written from the requirements
    int m_mode, m_deb, m_wk;
    bit m_wake, m_inh, m_term, m_txen, m_txdom, m_rxd, m_tsd;

    function automatic int next_mode(input int md, input bit w, input bit en, input bit uv,
                                     input bit bd, input bit dd, input bit wd, output bit nw);
        nw = w;
        case (md)
            0: if (en && !uv) begin nw = 0; return 1; end
            1: begin nw = 0; if (uv) return 0; if (dd && !en) return 2; end
            default: begin
                if (en && !uv) begin nw = 0; return 1; end
                if (wd && bd) begin nw = 1; return 0; end
            end
        endcase
        return md;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_wake = 0; m_deb = 0; m_wk = 0;
            m_inh = 1; m_term = 1; m_txen = 0; m_txdom = 0; m_rxd = 1; m_tsd = 0;
        end else begin
            int nm; bit nw;
            nm = next_mode(m_mode, m_wake, en_pin, vcc_uv, bus_dom, m_deb == DEB, m_wk == WAKE, nw);
            if (m_mode != 1 || en_pin) m_deb = 0;
            else if (tick_us && m_deb != DEB) m_deb++;
            if (m_mode != 2 || !bus_dom) m_wk = 0;
            else if (tick_us && m_wk != WAKE) m_wk++;
            m_inh   = (nm != 2);
            m_term  = (nm != 2);
            m_txen  = (nm == 1) && !over_temp && !vcc_uv;
            m_txdom = m_txen && !txd;
            m_rxd   = nw ? 1'b0 : (nm == 1) ? !bus_dom : 1'b1;
            m_tsd   = over_temp;
            m_mode  = nm; m_wake = nw;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
        if (cmp_on) begin
            chk("R11 mode_code", mode_code, m_mode);
            chk("R4 inh_drive", inh_drive, m_inh);
            chk("R4 term_en", term_en, m_term);
            chk("R10 tx_enable", tx_enable, m_txen);
            chk("R10 tx_dom", tx_dom, m_txdom);
            chk("R6 rxd", rxd, m_rxd);
            chk("R9 tsd_flag", tsd_flag, m_tsd);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        wait_n(3);
        chk("R1 reset mode", mode_code, 0);
        chk("R1 reset inh", inh_drive, 1);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        wait_n(2);
        chk("R1 standby term", term_en, 1);
        chk("R1 standby tx off", tx_enable, 0);
        chk("R1 standby rxd", rxd, 1);

        en_pin = 1; wait_n(2);
        chk("R2 to normal", mode_code, 1);
        txd = 0; wait_n(2);
        chk("R10 dominant drive", tx_dom, 1);
        txd = 1; wait_n(2);
        chk("R10 recessive", tx_dom, 0);
        bus_dom = 1; wait_n(2);
        chk("R11 rxd follows bus", rxd, 0);
        bus_dom = 0; wait_n(2);

        en_pin = 0; wait_n(10 * TDIV); en_pin = 1; wait_n(2);
        chk("R3 short enable low ignored", mode_code, 1);
        en_pin = 0; wait_n(DEB * TDIV + 12);
        chk("R3 sleep entered", mode_code, 2);
        chk("R4 inhibit floats", inh_drive, 0);
        chk("R4 termination off", term_en, 0);

        bus_dom = 1; wait_n(40 * TDIV); bus_dom = 0; wait_n(4);
        chk("R5 short dominant ignored", mode_code, 2);
        bus_dom = 1; wait_n(WAKE * TDIV + 12);
        chk("R5 remote wake to standby", mode_code, 0);
        chk("R5 inhibit driven", inh_drive, 1);
        chk("R6 wake interrupt", rxd, 0);
        bus_dom = 0; wait_n(20);
        chk("R6 interrupt held", rxd, 0);
        en_pin = 1; wait_n(2);
        chk("R6 cleared in normal", rxd, 1);

        en_pin = 0; wait_n(DEB * TDIV + 12);
        chk("R7 back asleep", mode_code, 2);
        en_pin = 1; wait_n(2);
        chk("R7 local wake", mode_code, 1);

        over_temp = 1; wait_n(2);
        chk("R9 tx off", tx_enable, 0);
        chk("R9 mode kept", mode_code, 1);
        chk("R9 flag", tsd_flag, 1);
        bus_dom = 1; wait_n(2);
        chk("R9 receiver alive", rxd, 0);
        over_temp = 0; bus_dom = 0; wait_n(2);
        chk("R9 tx restored", tx_enable, 1);

        vcc_uv = 1; wait_n(2);
        chk("R8 undervoltage standby", mode_code, 0);
        chk("R8 tx off", tx_enable, 0);
        wait_n(10);
        chk("R2 held while undervoltage", mode_code, 0);
        vcc_uv = 0; wait_n(2);
        chk("R2 normal after recovery", mode_code, 1);

        for (int s = 0; s < 150; s++) begin
            int len;
            en_pin    = ($urandom % 100) < 50;
            bus_dom   = ($urandom % 100) < 40;
            vcc_uv    = ($urandom % 100) < 10;
            over_temp = ($urandom % 100) < 15;
            len = 1 + $urandom % 500;
            for (int c = 0; c < len; c++) begin
                txd = $urandom % 2;
                @(negedge clk);
            end
        end
        finish_run();
    end
endmodule